// File: doc/BRIEF.md
# Palette Lookup Table Port

This block is a color palette for a display pipeline. It holds a 256-entry table of 24-bit colors (one byte each for red, green and blue). It also turns incoming pixels into 24-bit RGB values. A host loads the table over a byte-wide write port. It first writes a starting index to the shared address register. It then streams bytes to the table data port, three per entry, in the fixed order red, green, blue. After each complete triplet the address moves on to the next entry, so a host can fill the whole table from one starting address.

The same address register selects one of four indirect control registers. These are reached through a separate control data select and hold the following settings:
- the pixel format;
- a blanking flag;
- an index mask for indexed pixels;
- a flag that bypasses the table for direct-color pixels.

On the pixel side, three kinds of pixel are accepted:
- 8-bit indexed pixels, which select one table entry for all three channels;
- 16-bit 5-5-5 pixels;
- 32-bit x-8-8-8 pixels.

For the two direct-color kinds, each channel is looked up separately in its own column of the table, which gives per-channel gamma correction. Five-bit fields are first widened to eight bits by copying their top bits into the low bits. The result appears one clock after the pixel is presented.

Top module: `palette_lut_port`

## Requirements
- R1: Host select codes: 0 = address register, 1 = table data port, 2 = control data port, 3 = no target (writes ignored). A write to select 0 loads the address and resets the byte phase to red. The next three writes to select 1 store the red, green and blue bytes of the entry at that address. The entry takes effect when the blue byte is written.
- R2: After the blue byte is committed, the address register increments by one and wraps from 255 to 0. Reading select 0 on `host_rdata` returns the address register.
- R3: A write to the address register in the middle of a triplet discards the partial bytes. The next table write is taken as red for the new address, and nothing is committed for the interrupted triplet.
- R4: Control registers live at addresses 0x20 (format), 0x21 (blank), 0x10 (index mask) and 0x11 (bypass). Their reset values are 0x00, 0x00, 0xFF and 0x00. They are written and read through select 2 at the current address. At any other address, a control write has no effect and the readback is 0x00.
- R5: Bits 3:2 of register 0x20 select the pixel format: 00 = 8-bit indexed, 01 = 16-bit 5-5-5, 10 = 32-bit x-8-8-8. The value 11 behaves as 8-bit indexed.
- R6: In 8-bit mode, `pix_data[7:0]` ANDed with register 0x10 selects one entry, and all three outputs come from that entry. `pix_data[31:8]` is ignored.
- R7: In 16-bit mode, red is in bits 14:10, green in bits 9:5 and blue in bits 4:0. Each 5-bit field v is widened to {v, v[4:2]}, and that value indexes its own channel column of the table. Bits 31:15 are ignored.
- R8: In 32-bit mode, red is in bits 23:16, green in bits 15:8 and blue in bits 7:0. Each field indexes its own channel column. Bits 31:24 are ignored.
- R9: When bit 0 of register 0x11 is set, the 16-bit and 32-bit modes output the (widened) field values directly, without the table. The 8-bit mode is unaffected by this bit.
- R10: When bit 0 of register 0x21 is set, a valid output pixel is all zero.
- R11: `out_valid` follows `pix_valid` one clock later. The RGB outputs read zero whenever `out_valid` is low, including after reset.
- R12: Control writes and select-3 writes leave the address register and the byte phase unchanged. A triplet can therefore be interrupted by a control write and still complete at the original address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_sel | input | 2 | Host target select (0 address, 1 table data, 2 control data, 3 none) |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Readback of address register (select 0) or addressed control register (select 2), else zero |
| pix_valid | input | 1 | Pixel input valid |
| pix_data | input | 32 | Pixel word, interpreted by the format field |
| out_valid | output | 1 | Output pixel valid, one cycle after input |
| out_red | output | 8 | Output red channel |
| out_green | output | 8 | Output green channel |
| out_blue | output | 8 | Output blue channel |

## Verification
The bench builds the block with its default 8-bit channel width, which gives 256 entries. With that width, all 768 loading bytes fit in a short run, so the address wrap from 255 to 0 is reached both by a full table fill and by a single load at the last index. Because the full table holds distinct, known contents, every direct-color lookup can be traced to a specific column entry. That includes the widened 5-bit indices at the extreme field values 0 and 31.

// File: rtl/palette_pkg.sv
package palette_pkg;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_LUT  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_NONE = 2'd3
  } host_sel_e;

  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    FMT_IDX8    = 2'd0,
    FMT_RGB555  = 2'd1,
    FMT_XRGB888 = 2'd2,
    FMT_RSVD    = 2'd3
  } pix_fmt_e;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // Indirect control register map: slot order is format, blank, mask, bypass
  localparam int NUM_CREG = 4;
  localparam logic [7:0] CREG_ADDR [NUM_CREG] = '{8'h20, 8'h21, 8'h10, 8'h11};
  localparam logic [7:0] CREG_RST  [NUM_CREG] = '{8'h00, 8'h00, 8'hFF, 8'h00};
  localparam int SLOT_FMT    = 0;
  localparam int SLOT_BLANK  = 1;
  localparam int SLOT_MASK   = 2;
  localparam int SLOT_BYPASS = 3;

  // Five-bit channel to eight bits by repeating the top bits below
  function automatic logic [7:0] widen5(input logic [4:0] v);
    return {v, v[4:2]};
  endfunction

  function automatic logic is_direct(input pix_fmt_e fmt);
    return (fmt == FMT_RGB555) || (fmt == FMT_XRGB888);
  endfunction

  // Per-channel table index for a pixel word under a format
  function automatic rgb_t pixel_index(input pix_fmt_e fmt,
                                       input logic [31:0] px,
                                       input logic [7:0] mask);
    rgb_t idx;
    case (fmt)
      FMT_RGB555: begin
        idx.r = widen5(px[14:10]);
        idx.g = widen5(px[9:5]);
        idx.b = widen5(px[4:0]);
      end
      FMT_XRGB888: begin
        idx.r = px[23:16];
        idx.g = px[15:8];
        idx.b = px[7:0];
      end
      default: begin
        idx.r = px[7:0] & mask;
        idx.g = px[7:0] & mask;
        idx.b = px[7:0] & mask;
      end
    endcase
    return idx;
  endfunction

endpackage

// File: rtl/palette_host_seq.sv
module palette_host_seq
  import palette_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic [1:0]      host_sel,
  input  logic [CH_W-1:0] host_wdata,
  output logic [CH_W-1:0] addr_q,
  output logic            commit,
  output rgb_t            commit_rgb,
  output logic            ctrl_wr
);

  logic [CH_W-1:0] red_hold;
  logic [CH_W-1:0] green_hold;
  phase_e          phase_q;
  logic            addr_wr;
  logic            lut_wr;
  logic            none_wr;

  assign addr_wr = host_wr && (host_sel_e'(host_sel) == SEL_ADDR);
  assign lut_wr  = host_wr && (host_sel_e'(host_sel) == SEL_LUT);
  assign ctrl_wr = host_wr && (host_sel_e'(host_sel) == SEL_CTRL);
  assign none_wr = host_wr && (host_sel_e'(host_sel) == SEL_NONE);

  // Blue byte completes the triplet
  assign commit     = lut_wr && (phase_q == PH_BLUE);
  assign commit_rgb = '{r: red_hold, g: green_hold, b: host_wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      phase_q    <= PH_RED;
      red_hold   <= '0;
      green_hold <= '0;
    end else if (addr_wr) begin
      addr_q  <= host_wdata;
      phase_q <= PH_RED;
    end else if (lut_wr) begin
      case (phase_q)
        PH_RED: begin
          red_hold <= host_wdata;
          phase_q  <= PH_GREEN;
        end
        PH_GREEN: begin
          green_hold <= host_wdata;
          phase_q    <= PH_BLUE;
        end
        default: begin
          addr_q  <= addr_q + 1'b1;
          phase_q <= PH_RED;
        end
      endcase
    end
  end

  AST_COMMIT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (addr_q == $past(addr_q) + 1'b1)); // R2

  AST_ADDR_RESTARTS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (phase_q == PH_RED)); // R3

  AST_SIDE_WRITE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr || none_wr) |=> ($stable(addr_q) && $stable(phase_q))); // R12

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    phase_q != phase_e'(2'd3)); // R1

endmodule

// File: rtl/palette_ctrl_regs.sv
module palette_ctrl_regs
  import palette_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctrl_wr,
  input  logic [CH_W-1:0] addr,
  input  logic [CH_W-1:0] wdata,
  output logic [CH_W-1:0] rd_val,
  output pix_fmt_e        fmt,
  output logic            blank,
  output logic [CH_W-1:0] mask,
  output logic            bypass
);

  logic [CH_W-1:0]     creg [NUM_CREG];
  logic [NUM_CREG-1:0] hit;

  for (genvar i = 0; i < NUM_CREG; i++) begin : g_creg
    assign hit[i] = (addr == CREG_ADDR[i]);
    always_ff @(posedge clk) begin
      if (!rst_n)
        creg[i] <= CREG_RST[i];
      else if (ctrl_wr && hit[i])
        creg[i] <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_CREG; i++)
      if (hit[i]) rd_val = creg[i];
  end

  assign fmt    = pix_fmt_e'(creg[SLOT_FMT][3:2]);
  assign blank  = creg[SLOT_BLANK][0];
  assign mask   = creg[SLOT_MASK];
  assign bypass = creg[SLOT_BYPASS][0];

  AST_MAP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit)); // R4

  AST_UNMAPPED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && (hit == '0)) |=>
      ($stable(creg[0]) && $stable(creg[1]) && $stable(creg[2]) && $stable(creg[3]))); // R4

endmodule

// File: rtl/palette_chan_ram.sv
module palette_chan_ram #(
  parameter int CH_W = 8,
  localparam int DEPTH = 1 << CH_W
) (
  input  logic            clk,
  input  logic            wr_en,
  input  logic [CH_W-1:0] wr_addr,
  input  logic [CH_W-1:0] wr_data,
  input  logic [CH_W-1:0] rd_addr,
  output logic [CH_W-1:0] rd_q
);

  logic [CH_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/palette_pix_path.sv
module palette_pix_path
  import palette_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  pix_fmt_e        fmt,
  input  logic [CH_W-1:0] mask,
  input  logic            bypass,
  input  logic            blank,
  input  logic            pix_valid,
  input  logic [31:0]     pix_data,
  output rgb_t            rd_idx,
  input  rgb_t            ram_q,
  output logic            out_valid,
  output rgb_t            out_rgb
);

  logic valid_q;
  logic blank_q;
  logic raw_q;
  rgb_t idx_q;

  assign rd_idx = pixel_index(fmt, pix_data, mask);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      blank_q <= 1'b0;
      raw_q   <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= pix_valid;
      blank_q <= blank;
      raw_q   <= bypass && is_direct(fmt);
      idx_q   <= rd_idx;
    end
  end

  assign out_valid = valid_q;
  assign out_rgb   = (!valid_q || blank_q) ? '0 : (raw_q ? idx_q : ram_q);

  AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid); // R11

  AST_BLANK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && blank) |=> (out_rgb == '0)); // R10

  AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && bypass && !blank && fmt == FMT_XRGB888) |=>
      (out_rgb == $past(pix_data[23:0]))); // R9

endmodule

// File: rtl/palette_lut_port.sv
module palette_lut_port
  import palette_pkg::*;
#(
  parameter int CH_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            host_wr,
  input  logic [1:0]      host_sel,
  input  logic [CH_W-1:0] host_wdata,
  output logic [CH_W-1:0] host_rdata,
  input  logic            pix_valid,
  input  logic [31:0]     pix_data,
  output logic            out_valid,
  output logic [CH_W-1:0] out_red,
  output logic [CH_W-1:0] out_green,
  output logic [CH_W-1:0] out_blue
);

  localparam int NCH = 3;

  logic [CH_W-1:0] addr_q;
  logic            commit;
  rgb_t            commit_rgb;
  logic            ctrl_wr;
  logic [CH_W-1:0] creg_rd;
  pix_fmt_e        fmt;
  logic            blank;
  logic [CH_W-1:0] mask;
  logic            bypass;
  rgb_t            rd_idx;
  rgb_t            ram_q;
  rgb_t            out_rgb;

  logic [NCH-1:0][CH_W-1:0] wr_word;
  logic [NCH-1:0][CH_W-1:0] idx_word;
  logic [NCH-1:0][CH_W-1:0] q_word;

  palette_host_seq #(.CH_W(CH_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .addr_q     (addr_q),
    .commit     (commit),
    .commit_rgb (commit_rgb),
    .ctrl_wr    (ctrl_wr)
  );

  palette_ctrl_regs #(.CH_W(CH_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctrl_wr (ctrl_wr),
    .addr    (addr_q),
    .wdata   (host_wdata),
    .rd_val  (creg_rd),
    .fmt     (fmt),
    .blank   (blank),
    .mask    (mask),
    .bypass  (bypass)
  );

  // Channel columns: word slot 2 = red, 1 = green, 0 = blue
  assign wr_word  = commit_rgb;
  assign idx_word = rd_idx;
  assign ram_q    = q_word;

  for (genvar c = 0; c < NCH; c++) begin : g_col
    palette_chan_ram #(.CH_W(CH_W)) u_ram (
      .clk     (clk),
      .wr_en   (commit),
      .wr_addr (addr_q),
      .wr_data (wr_word[c]),
      .rd_addr (idx_word[c]),
      .rd_q    (q_word[c])
    );
  end

  palette_pix_path #(.CH_W(CH_W)) u_pix (
    .clk       (clk),
    .rst_n     (rst_n),
    .fmt       (fmt),
    .mask      (mask),
    .bypass    (bypass),
    .blank     (blank),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .rd_idx    (rd_idx),
    .ram_q     (ram_q),
    .out_valid (out_valid),
    .out_rgb   (out_rgb)
  );

  always_comb begin
    case (host_sel_e'(host_sel))
      SEL_ADDR: host_rdata = addr_q;
      SEL_CTRL: host_rdata = creg_rd;
      default:  host_rdata = '0;
    endcase
  end

  assign out_red   = out_rgb.r;
  assign out_green = out_rgb.g;
  assign out_blue  = out_rgb.b;

endmodule

// File: tb/tb_palette_lut_port.sv
module tb_palette_lut_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [1:0]  host_sel = 2'd3;
  logic [7:0]  host_wdata = '0;
  logic [7:0]  host_rdata;
  logic        pix_valid = 1'b0;
  logic [31:0] pix_data = '0;
  logic        out_valid;
  logic [7:0]  out_red, out_green, out_blue;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Bench model of table and settings
  logic [7:0] mr [256];
  logic [7:0] mg [256];
  logic [7:0] mb [256];
  logic [7:0] m_mask = 8'hFF;
  int         m_mode = 0;
  bit         m_bypass = 1'b0;
  bit         m_blank = 1'b0;

  always #5 clk = ~clk;

  palette_lut_port dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .pix_valid(pix_valid),
    .pix_data(pix_data), .out_valid(out_valid), .out_red(out_red),
    .out_green(out_green), .out_blue(out_blue)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hw(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_sel = sel; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0; host_sel = 2'd3;
  endtask

  task automatic hread(input logic [1:0] sel, output logic [7:0] v);
    @(negedge clk);
    host_sel = sel;
    #1 v = host_rdata;
    host_sel = 2'd3;
  endtask

  task automatic load(input logic [7:0] a, input logic [7:0] r,
                      input logic [7:0] g, input logic [7:0] b);
    hw(2'd0, a); hw(2'd1, r); hw(2'd1, g); hw(2'd1, b);
    mr[a] = r; mg[a] = g; mb[a] = b;
  endtask

  task automatic set_ctrl(input logic [7:0] a, input logic [7:0] v);
    hw(2'd0, a); hw(2'd2, v);
    case (a)
      8'h20: m_mode = int'(v[3:2]);
      8'h21: m_blank = v[0];
      8'h10: m_mask = v;
      8'h11: m_bypass = v[0];
      default: ;
    endcase
  endtask

  function automatic logic [7:0] w5(input logic [4:0] f);
    return 8'((f << 3) | (f >> 2));
  endfunction

  function automatic logic [23:0] expect_px(input logic [31:0] p);
    logic [7:0] ri, gi, bi;
    if (m_blank) return 24'h0;
    if (m_mode == 1) begin
      ri = w5(p[14:10]); gi = w5(p[9:5]); bi = w5(p[4:0]);
    end else if (m_mode == 2) begin
      ri = p[23:16]; gi = p[15:8]; bi = p[7:0];
    end else begin
      ri = p[7:0] & m_mask; gi = ri; bi = ri;
      return {mr[ri], mg[gi], mb[bi]};
    end
    if (m_bypass) return {ri, gi, bi};
    return {mr[ri], mg[gi], mb[bi]};
  endfunction

  task automatic pix(input string req, input logic [31:0] p);
    logic [23:0] e;
    e = expect_px(p);
    @(negedge clk);
    pix_valid = 1'b1; pix_data = p;
    @(negedge clk);
    pix_valid = 1'b0; pix_data = 32'hDEAD_BEEF;
    chk({req, " valid"}, 32'(out_valid), 32'd1);
    chk(req, {8'h0, out_red, out_green, out_blue}, {8'h0, e});
    @(negedge clk);
    chk({req, " idle"}, {7'h0, out_valid, out_red, out_green, out_blue}, 32'h0);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R11 reset valid", 32'(out_valid), 0);
    chk("R11 reset rgb", {8'h0, out_red, out_green, out_blue}, 0);
    hread(2'd0, v); chk("R2 reset addr", 32'(v), 0);
    hw(2'd0, 8'h20); hread(2'd2, v); chk("R4 reset 0x20", 32'(v), 32'h00);
    hw(2'd0, 8'h21); hread(2'd2, v); chk("R4 reset 0x21", 32'(v), 32'h00);
    hw(2'd0, 8'h10); hread(2'd2, v); chk("R4 reset 0x10", 32'(v), 32'hFF);
    hw(2'd0, 8'h11); hread(2'd2, v); chk("R4 reset 0x11", 32'(v), 32'h00);
  endtask

  task automatic t_fill();
    logic [7:0] v;
    hw(2'd0, 8'h00);
    for (int i = 0; i < 256; i++) begin
      mr[i] = 8'(i) ^ 8'h5A; mg[i] = 8'(i + 8'h33); mb[i] = ~8'(i);
      hw(2'd1, mr[i]); hw(2'd1, mg[i]); hw(2'd1, mb[i]);
    end
    hread(2'd0, v); chk("R2 fill wraps to 0", 32'(v), 0);
    pix("R1 fill entry 0x00", 32'h0000_0000);
    pix("R1 fill entry 0x80", 32'h0000_0080);
    pix("R6 upper bits ignored", 32'hFFFF_FF37);
  endtask

  task automatic t_load_single();
    logic [7:0] v;
    load(8'h05, 8'h11, 8'h22, 8'h33);
    hread(2'd0, v); chk("R2 advance after triplet", 32'(v), 32'h06);
    pix("R1 single load", 32'h0000_0005);
    load(8'hFF, 8'hA1, 8'hB2, 8'hC3);
    hread(2'd0, v); chk("R2 wrap 255 to 0", 32'(v), 0);
    pix("R2 entry 255", 32'h0000_00FF);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    hw(2'd0, 8'h10); hw(2'd1, 8'hEE); hw(2'd1, 8'hDD);
    load(8'h10, 8'h01, 8'h02, 8'h03);
    hread(2'd0, v); chk("R3 address after restart", 32'(v), 32'h11);
    pix("R3 restarted triplet", 32'h0000_0010);
    pix("R3 next entry untouched", 32'h0000_0011);
  endtask

  task automatic t_side_writes();
    logic [7:0] v;
    hw(2'd0, 8'h40); hw(2'd1, 8'h44); hw(2'd1, 8'h55);
    hw(2'd2, 8'h99); hw(2'd3, 8'h77); hw(2'd1, 8'h66);
    mr[8'h40] = 8'h44; mg[8'h40] = 8'h55; mb[8'h40] = 8'h66;
    hread(2'd0, v); chk("R12 triplet finishes after side writes", 32'(v), 32'h41);
    pix("R12 entry intact", 32'h0000_0040);
    hread(2'd2, v); chk("R4 unmapped readback zero", 32'(v), 0);
    hw(2'd0, 8'h10); hread(2'd2, v); chk("R4 mask unchanged by unmapped write", 32'(v), 32'hFF);
  endtask

  task automatic t_ctrl_rw();
    logic [7:0] v;
    set_ctrl(8'h11, 8'h00);
    set_ctrl(8'h21, 8'hFE);
    hread(2'd2, v); chk("R4 0x21 readback", 32'(v), 32'hFE);
    pix("R10 blank bit clear", 32'h0000_0022);
  endtask

  task automatic t_mask();
    set_ctrl(8'h10, 8'h0F);
    pix("R6 mask applied", 32'h0000_0045);
    set_ctrl(8'h10, 8'hFF);
    pix("R6 mask restored", 32'h0000_0045);
  endtask

  task automatic t_rgb555();
    set_ctrl(8'h20, 8'h04);
    pix("R7 555 mid values", 32'h0000_2A55);
    pix("R7 555 extremes", 32'h0000_7C00);
    pix("R7 bit 15 and upper ignored", 32'hFFFF_83FF);
    set_ctrl(8'h11, 8'h01);
    pix("R9 555 bypass widened", 32'h0000_4631);
    set_ctrl(8'h11, 8'h00);
  endtask

  task automatic t_xrgb888();
    set_ctrl(8'h20, 8'h08);
    pix("R8 888 lookup", 32'h0012_3456);
    pix("R8 top byte ignored", 32'hAB12_3456);
    set_ctrl(8'h11, 8'h01);
    pix("R9 888 bypass raw", 32'h00C0_FFEE);
    set_ctrl(8'h20, 8'h00);
    pix("R9 bypass no effect on 8-bit", 32'h0000_0005);
    set_ctrl(8'h11, 8'h00);
  endtask

  task automatic t_mode_rsvd_and_blank();
    set_ctrl(8'h20, 8'h0C);
    pix("R5 format 11 acts as 8-bit", 32'h0000_1234);
    set_ctrl(8'h20, 8'h08);
    set_ctrl(8'h21, 8'h01);
    pix("R10 blank forces zero", 32'h0012_3456);
    set_ctrl(8'h21, 8'h00);
    set_ctrl(8'h20, 8'h00);
  endtask

  task automatic t_latency();
    @(negedge clk);
    pix_valid = 1'b1; pix_data = 32'h5;
    #1 chk("R11 no same-cycle output", 32'(out_valid), 0);
    @(negedge clk);
    pix_valid = 1'b0;
    chk("R11 one-cycle latency", 32'(out_valid), 1);
    @(negedge clk);
    chk("R11 valid drops", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill();
    t_load_single();
    t_restart();
    t_side_writes();
    t_ctrl_rw();
    t_mask();
    t_rgb555();
    t_xrgb888();
    t_mode_rsvd_and_blank();
    t_latency();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule